// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the instruction fetch address of a small 4-bit controller. The address has two parts: a 6-bit word counter that moves through the 64 words of a page, and a 4-bit page register that selects one of 16 pages. During straight-line execution only the word counter advances. When it passes the last word it wraps back to word 0 of the same page. The page does not change on its own.

An instruction can carry only six address bits, so a change of page takes two steps. First, a load-page-buffer step places the target page in a staging buffer. Then a taken branch or call copies that buffer into the page register and loads the operand into the word counter. A call also saves the return point (the page, plus the word after the call) on a three-entry stack. A return restores both the page and the word from that stack.

The instruction decoder drives the control strobes, the operand and the status flag for each step. A step takes effect only while `step_en` is high.

Top module: `prog_addr_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0 and `stack_ovf` is 0. The page buffer and the stack are also cleared, so a taken branch as the first step after reset lands on page 0.
- R2: A step with no control strobe sets word = (word + 1) mod 64 and leaves the page unchanged. Passing word 63 returns to word 0 of the same page. `fetch_addr` is {page, word}, with the page in bits 9:6 and the word in bits 5:0.
- R3: While `step_en` is low, no input has any effect: `fetch_addr`, the buffer and the stack all hold their values.
- R4: A load-page-buffer step writes `pb_imm` into the page buffer and increments the word. The page register does not change.
- R5: A branch step with `status` = 1 copies the page buffer into the page register and loads `operand` into the word counter.
- R6: A branch or call step with `status` = 0 only increments the word. It pushes nothing, and the page buffer keeps its value.
- R7: A call step with `status` = 1 pushes {page, (word + 1) mod 64} and then performs the same jump as R5.
- R8: A return step pops the most recent entry and loads both the page and the word from it. This holds whatever the value of `status`.
- R9: The stack holds 3 entries. A push onto a full stack discards the oldest entry and sets `stack_ovf`. The flag stays set until reset.
- R10: A return step with an empty stack goes to word 0 of page 0.
- R11: When several strobes are high in one step, only the highest-priority one acts. The order, highest first, is return, call, branch, load-page-buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | One instruction step is taken this cycle |
| ld_pb | input | 1 | Load-page-buffer strobe |
| pb_imm | input | 4 | Immediate page for the buffer |
| br | input | 1 | Conditional branch strobe |
| cal | input | 1 | Conditional call strobe |
| rtn | input | 1 | Return strobe |
| operand | input | 6 | Target word for a branch or call |
| status | input | 1 | Condition flag; 1 means take the branch or call |
| fetch_addr | output | 10 | {page, word} fetch address |
| stack_ovf | output | 1 | Sticky stack overflow flag |

## Verification
The hardest state to reach is a full stack holding entries from several different pages. A fourth call must then push out the oldest entry, and the returns that follow must unwind past the discarded frame into an empty pop. To get there, the stimulus chains calls across pages, reloading the buffer before each call. It then issues one more return than there are surviving entries. Random strobe mixes, with the status flag toggling, cover the priority order and the untaken cases. A behavioural queue model checks every step.

// File: rtl/pas_pkg.sv
package pas_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_SEQ,
    ACT_LDPB,
    ACT_JUMP,
    ACT_CALL,
    ACT_RET
  } seq_act_e;
endpackage

// File: rtl/pas_return_stack.sv
module pas_return_stack #(
  parameter int ENT_W = 10,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [ENT_W-1:0] push_data,
  output logic [ENT_W-1:0] top_data,
  output logic             ovf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int VEC_W = DEPTH * ENT_W;

  logic [VEC_W-1:0] stk_q, stk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             full, empty;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  // entry 0 sits in the low bits; a push moves older entries upward
  generate
    if (DEPTH == 1) begin : g_single
      always_comb begin
        stk_d = stk_q;
        if (push)     stk_d = push_data;
        else if (pop) stk_d = '0;
      end
    end else begin : g_multi
      always_comb begin
        stk_d = stk_q;
        if (push)     stk_d = {stk_q[VEC_W-ENT_W-1:0], push_data};
        else if (pop) stk_d = {{ENT_W{1'b0}}, stk_q[VEC_W-1:ENT_W]};
      end
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (push) begin
      if (full) ovf_d = 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (push || pop) begin
      stk_q <= stk_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign top_data = empty ? '0 : stk_q[ENT_W-1:0];
  assign ovf      = ovf_q;
endmodule

// File: rtl/pas_page_ctrl.sv
module pas_page_ctrl
  import pas_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_act_e          act,
  input  logic [PAGE_W-1:0] imm,
  input  logic [PAGE_W-1:0] ret_page,
  output logic [PAGE_W-1:0] page
);
  logic [PAGE_W-1:0] buf_q, buf_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              en;

  assign en = (act != ACT_HOLD);

  always_comb begin
    buf_d  = buf_q;
    page_d = page_q;
    case (act)
      ACT_LDPB:          buf_d  = imm;
      ACT_JUMP, ACT_CALL: page_d = buf_q;
      ACT_RET:           page_d = ret_page;
      default:           ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      page_q <= '0;
    end else if (en) begin
      buf_q  <= buf_d;
      page_q <= page_d;
    end
  end

  assign page = page_q;
endmodule

// File: rtl/pas_word_ctr.sv
module pas_word_ctr
  import pas_pkg::*;
#(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_act_e          act,
  input  logic [WORD_W-1:0] operand,
  input  logic [WORD_W-1:0] ret_word,
  output logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] word_inc
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              en;

  assign en       = (act != ACT_HOLD);
  assign word_inc = word_q + 1'b1;

  always_comb begin
    case (act)
      ACT_JUMP, ACT_CALL: word_d = operand;
      ACT_RET:            word_d = ret_word;
      ACT_HOLD:           word_d = word_q;
      default:            word_d = word_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (en) word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
  import pas_pkg::*;
#(
  parameter int WORD_W    = 6,
  parameter int PAGE_W    = 4,
  parameter int STK_DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_en,
  input  logic                     ld_pb,
  input  logic [PAGE_W-1:0]        pb_imm,
  input  logic                     br,
  input  logic                     cal,
  input  logic                     rtn,
  input  logic [WORD_W-1:0]        operand,
  input  logic                     status,
  output logic [WORD_W+PAGE_W-1:0] fetch_addr,
  output logic                     stack_ovf
);
  localparam int ADDR_W = WORD_W + PAGE_W;

  seq_act_e          act;
  logic [PAGE_W-1:0] page;
  logic [WORD_W-1:0] word, word_inc;
  logic [ADDR_W-1:0] ret_addr;

  always_comb begin
    if (!step_en)  act = ACT_HOLD;
    else if (rtn)  act = ACT_RET;
    else if (cal)  act = status ? ACT_CALL : ACT_SEQ;
    else if (br)   act = status ? ACT_JUMP : ACT_SEQ;
    else if (ld_pb) act = ACT_LDPB;
    else           act = ACT_SEQ;
  end

  pas_word_ctr #(.WORD_W(WORD_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .operand  (operand),
    .ret_word (ret_addr[WORD_W-1:0]),
    .word     (word),
    .word_inc (word_inc)
  );

  pas_page_ctrl #(.PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .imm      (pb_imm),
    .ret_page (ret_addr[ADDR_W-1:WORD_W]),
    .page     (page)
  );

  pas_return_stack #(.ENT_W(ADDR_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (act == ACT_CALL),
    .pop       (act == ACT_RET),
    .push_data ({page, word_inc}),
    .top_data  (ret_addr),
    .ovf       (stack_ovf)
  );

  assign fetch_addr = {page, word};
endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
  parameter int WORD_W = 6,
  parameter int PAGE_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     step_en,
  input logic                     br,
  input logic                     cal,
  input logic                     rtn,
  input logic [WORD_W-1:0]        operand,
  input logic                     status,
  input logic [WORD_W+PAGE_W-1:0] fetch_addr,
  input logic                     stack_ovf
);
  localparam int ADDR_W = WORD_W + PAGE_W;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (fetch_addr == '0) && !stack_ovf);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(fetch_addr));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !br && !cal && !rtn |=>
      (fetch_addr[WORD_W-1:0] == $past(fetch_addr[WORD_W-1:0]) + 1'b1) &&
      (fetch_addr[ADDR_W-1:WORD_W] == $past(fetch_addr[ADDR_W-1:WORD_W])));

  // R5
  taken_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !rtn && (br || cal) && status |=>
      fetch_addr[WORD_W-1:0] == $past(operand));

  // R6
  not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !rtn && (br || cal) && !status |=>
      (fetch_addr[WORD_W-1:0] == $past(fetch_addr[WORD_W-1:0]) + 1'b1) &&
      $stable(fetch_addr[ADDR_W-1:WORD_W]));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);
endmodule

bind prog_addr_seq pas_checker #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_pas_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_en    (step_en),
  .br         (br),
  .cal        (cal),
  .rtn        (rtn),
  .operand    (operand),
  .status     (status),
  .fetch_addr (fetch_addr),
  .stack_ovf  (stack_ovf)
);

// File: tb/test_prog_addr_seq.sv
`timescale 1ns/1ps
module test_prog_addr_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en, ld_pb, br, cal, rtn, status;
  logic [3:0] pb_imm;
  logic [5:0] operand;
  logic [9:0] fetch_addr;
  logic       stack_ovf;

  int checks = 0;
  int failures = 0;

  int m_page, m_word, m_pb;
  bit m_ovf;
  int m_stk[$];

  always #2.5 clk = ~clk;

  prog_addr_seq i_prog_addr_seq (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ld_pb(ld_pb),
    .pb_imm(pb_imm), .br(br), .cal(cal), .rtn(rtn), .operand(operand),
    .status(status), .fetch_addr(fetch_addr), .stack_ovf(stack_ovf)
  );

  function automatic void model_reset();
    m_page = 0; m_word = 0; m_pb = 0; m_ovf = 0;
    m_stk.delete();
  endfunction

  function automatic void model_step(bit s, bit lp, int imm, bit b, bit c,
                                     bit r, int op, bit st);
    if (!s) return;
    if (r) begin
      if (m_stk.size() == 0) begin m_page = 0; m_word = 0; end
      else begin
        int e = m_stk.pop_front();
        m_page = e / 64; m_word = e % 64;
      end
    end else if (c && st) begin
      m_stk.push_front(m_page * 64 + (m_word + 1) % 64);
      if (m_stk.size() > 3) begin void'(m_stk.pop_back()); m_ovf = 1; end
      m_page = m_pb; m_word = op;
    end else if (b && st) begin
      m_page = m_pb; m_word = op;
    end else begin
      if (!c && !b && lp) m_pb = imm;
      m_word = (m_word + 1) % 64;
    end
  endfunction

  task automatic compare(string tag);
    int exp_a = m_page * 64 + m_word;
    checks++;
    if (fetch_addr !== 10'(exp_a) || stack_ovf !== m_ovf) begin
      failures++;
      $display("FAIL %s: addr=%0h ovf=%0b expected addr=%0h ovf=%0b",
               tag, fetch_addr, stack_ovf, exp_a, m_ovf);
    end
  endtask

  task automatic cyc(bit s, bit lp, int imm, bit b, bit c, bit r, int op,
                     bit st, string tag);
    step_en = s; ld_pb = lp; pb_imm = 4'(imm); br = b; cal = c; rtn = r;
    operand = 6'(op); status = st;
    @(posedge clk);
    model_step(s, lp, imm, b, c, r, op, st);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic seq(string tag);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    step_en = 0; ld_pb = 0; br = 0; cal = 0; rtn = 0; status = 0;
    pb_imm = '0; operand = '0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst_n = 1'b1;
    // R1: buffer cleared, so a taken branch stays on page 0
    cyc(1, 0, 0, 1, 0, 0, 6'd17, 1, "R1 branch after reset");

    // R2: sequential run with wrap inside the page
    for (int i = 0; i < 50; i++) seq("R2 sequential");
    // R3: idle steps with strobes active change nothing
    for (int i = 0; i < 4; i++) cyc(0, 1, 9, 1, 1, 1, 5, 1, "R3 idle hold");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R3 idle hold");
    // R4: buffer load leaves page alone
    cyc(1, 1, 4'hA, 0, 0, 0, 0, 0, "R4 load buffer");
    for (int i = 0; i < 3; i++) seq("R4 page kept");
    // R6: untaken branch and call
    cyc(1, 0, 0, 1, 0, 0, 6'd3, 0, "R6 branch not taken");
    cyc(1, 0, 0, 0, 1, 0, 6'd3, 0, "R6 call not taken");
    // R5: taken branch picks up buffered page
    cyc(1, 0, 0, 1, 0, 0, 6'd62, 1, "R5 branch taken");
    seq("R2 wrap"); seq("R2 wrap"); seq("R2 wrap");
    // R7, R8: call into another page and return
    cyc(1, 1, 4'h3, 0, 0, 0, 0, 0, "R4 load buffer");
    cyc(1, 0, 0, 0, 1, 0, 6'd10, 1, "R7 call taken");
    seq("R2 in callee");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R8 return restores page");
    // R9: four nested calls across pages
    for (int i = 0; i < 4; i++) begin
      cyc(1, 1, 5 + i, 0, 0, 0, 0, 0, "R4 load buffer");
      cyc(1, 0, 0, 0, 1, 0, 8 * i + 1, 1, "R9 nested call");
    end
    // R8, R10: unwind three entries then pop empty
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 1, 0, 1, "R8 unwind");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R10 empty return");
    cyc(1, 0, 0, 0, 0, 1, 0, 1, "R10 empty return again");
    // R11: priority cases
    cyc(1, 1, 4'hC, 1, 1, 0, 6'd20, 1, "R11 call over branch and load");
    cyc(1, 1, 4'h7, 1, 0, 1, 6'd30, 1, "R11 return over all");
    cyc(1, 1, 4'h9, 1, 0, 0, 6'd40, 0, "R11 untaken branch blocks load");
    cyc(1, 0, 0, 1, 0, 0, 6'd41, 1, "R11 buffer unchanged");
    // mixed random traffic
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 7) != 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 15), $urandom_range(0, 4) == 0,
          $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
          $urandom_range(0, 63), $urandom_range(0, 1) == 1,
          "R11 random mix");
    // R1: reset clears sticky overflow
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    compare("R1 reset clears overflow");
    rst_n = 1'b1;
    seq("R2 after second reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule